// File: doc/BRIEF.md
# Fixed Load-Latency Equalizer

This unit sits between an in-order pipeline and a memory whose load latency varies from one access to the next. Each accepted load gets a tag, which the pipeline forwards to memory with the address. Responses come back tagged and may arrive in any order. The unit hands each load's data to the pipeline exactly N cycles after the load was accepted. N is a latency value that software programs.

Data that returns ahead of its due cycle waits in a per-tag buffer. If a load's due cycle arrives before its data, the unit raises `stall`. While `stall` is high, all pending countdowns freeze and no new load is accepted, so the pipeline sees time as standing still. A response that lands in its own due cycle is passed straight through. Up to eight loads may be in flight. A new latency value takes effect only while nothing is in flight.

Top module: `lat_equalizer`

## Requirements
- R1: After reset, `dlvValid` and `stall` are low, `issueReady` is high, no load is outstanding and the latency is 4.
- R2: A load accepted in cycle c (`issueValid` and `issueReady` high) with no stall in between is delivered in cycle c+N. In that cycle `dlvValid` is high, `dlvTag` is the load's tag and `dlvData` is its response data. N is at least 1.
- R3: A response that arrives before its load's due cycle is held. `dlvValid` stays low until the due cycle, and the data is delivered then.
- R4: A response that arrives in its load's due cycle is delivered in that same cycle, and `stall` stays low.
- R5: If the data is not back by the due cycle, `stall` is high from the due cycle up to the cycle before the response arrives. The load is delivered in the arrival cycle with `stall` low. `dlvValid` is never high together with `stall`.
- R6: While `stall` is high, every outstanding load's countdown is frozen. A load issued k cycles after an earlier one is delivered in cycle issue+N+S, where S is the number of stall cycles after its issue.
- R7: Tags are handed out as 0,1,...,7 and then wrap, one per accepted load, and appear on `issueTag` in the cycle of acceptance. `issueReady` is low while `stall` is high or while eight loads are outstanding.
- R8: Responses may come back in any tag order. Deliveries still occur in issue order.
- R9: A write on `latWrEn` sets the latency to `latWrVal` only if no load is outstanding, no load is accepted in that cycle and the value is non-zero. Any other write is ignored. The new value governs loads accepted afterwards.
- R10: A response whose tag does not belong to an outstanding load is ignored. It is neither buffered nor delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| latWrEn | input | 1 | Latency write strobe |
| latWrVal | input | LAT_W | Latency value to write |
| issueValid | input | 1 | Pipeline presents a load this cycle |
| issueReady | output | 1 | Load can be accepted this cycle |
| issueTag | output | TAG_W | Tag given to the load accepted this cycle |
| rspValid | input | 1 | Memory response valid |
| rspTag | input | TAG_W | Tag of the response |
| rspData | input | DATA_W | Response data |
| dlvValid | output | 1 | A load's data is delivered this cycle |
| dlvTag | output | TAG_W | Tag of the delivered load |
| dlvData | output | DATA_W | Delivered load data |
| stall | output | 1 | Due data missing; pipeline must freeze |

## Verification
A load accepted in cycle c is due for delivery in cycle c+N plus any stall cycles that occur after it issues. Its delivery flag, tag and data come from registered countdown state combined with the current response inputs, so they are valid within that same cycle. `stall` depends on the same terms and is due from the load's due cycle until the cycle its response is driven. The bench drives inputs just after the falling edge and samples the outputs one time unit later, comparing each cycle against a due cycle computed as max(N, response offset) for single loads and as issue offset+N+late cycles for overlapping loads. Sweeps cover several latencies against every response offset from early through late, pairs of overlapping loads with varied lateness, a full burst answered out of order, and ignored latency writes and stray responses.

// File: rtl/lateq_pkg.sv
package lateq_pkg;
  // Strobes from control to datapath, one per cycle
  typedef struct packed {
    logic deliver;   // head load leaves the unit this cycle
    logic bypass;    // head data comes straight from the response port
    logic capture;   // response is written into its tag's buffer entry
  } strobe_t;
endpackage

// File: rtl/lateq_slot.sv
module lateq_slot #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             advance,
  input  logic             retire,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= loadVal;
    end else begin
      if (retire) busy <= 1'b0;
      if (busy && advance && (cnt != '0)) cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/lateq_ctrl.sv
module lateq_ctrl
  import lateq_pkg::*;
#(
  parameter int TAG_W     = 3,
  parameter int LAT_W     = 4,
  parameter int LAT_RESET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latWrEn,
  input  logic [LAT_W-1:0] latWrVal,
  input  logic             issueValid,
  output logic             issueReady,
  output logic [TAG_W-1:0] issueTag,
  input  logic             rspValid,
  input  logic [TAG_W-1:0] rspTag,
  input  logic             headArrived,
  output logic             stall,
  output logic             dlvValid,
  output logic [TAG_W-1:0] headIdx,
  output strobe_t          stb
);
  localparam int               SLOTS    = 1 << TAG_W;
  localparam logic [TAG_W:0]   FULL_OCC = (TAG_W+1)'(SLOTS);
  localparam logic [LAT_W-1:0] LAT_INIT = LAT_W'(LAT_RESET);

  logic [LAT_W-1:0] latReg;
  logic [TAG_W-1:0] headPtr, tailPtr;
  logic [TAG_W:0]   occ;
  logic [SLOTS-1:0] slotBusy;
  logic [LAT_W-1:0] slotCnt [SLOTS];
  logic             issueFire, headDue, rspHitsHead, latAccept;

  assign headDue     = slotBusy[headPtr] && (slotCnt[headPtr] == '0);
  assign rspHitsHead = rspValid && (rspTag == headPtr);

  assign stall        = headDue && !headArrived && !rspHitsHead;
  assign stb.deliver  = headDue && (headArrived || rspHitsHead);
  assign stb.bypass   = headDue && !headArrived && rspHitsHead;
  assign stb.capture  = rspValid && slotBusy[rspTag] && !(stb.deliver && rspHitsHead);

  assign issueReady = (occ != FULL_OCC) && !stall;
  assign issueFire  = issueValid && issueReady;
  assign issueTag   = tailPtr;
  assign dlvValid   = stb.deliver;
  assign headIdx    = headPtr;

  assign latAccept = latWrEn && (occ == '0) && !issueFire && (latWrVal != '0);

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      lateq_slot #(.CNT_W(LAT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (issueFire && (tailPtr == TAG_W'(i))),
        .loadVal (latReg - LAT_W'(1)),
        .advance (!stall),
        .retire  (stb.deliver && (headPtr == TAG_W'(i))),
        .busy    (slotBusy[i]),
        .cnt     (slotCnt[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latReg  <= LAT_INIT;
      headPtr <= '0;
      tailPtr <= '0;
      occ     <= '0;
    end else begin
      if (latAccept)   latReg  <= latWrVal;
      if (issueFire)   tailPtr <= tailPtr + TAG_W'(1);
      if (stb.deliver) headPtr <= headPtr + TAG_W'(1);
      case ({issueFire, stb.deliver})
        2'b10:   occ <= occ + (TAG_W+1)'(1);
        2'b01:   occ <= occ - (TAG_W+1)'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/lateq_dpath.sv
module lateq_dpath
  import lateq_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [TAG_W-1:0]  headIdx,
  input  logic [TAG_W-1:0]  rspTag,
  input  logic [DATA_W-1:0] rspData,
  output logic              headArrived,
  output logic [DATA_W-1:0] dlvData
);
  localparam int SLOTS = 1 << TAG_W;

  logic [SLOTS-1:0]  arrived;
  logic [DATA_W-1:0] dataBuf [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arrived <= '0;
    end else begin
      if (stb.deliver) arrived[headIdx] <= 1'b0;
      if (stb.capture) arrived[rspTag]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.capture) dataBuf[rspTag] <= rspData;
  end

  assign headArrived = arrived[headIdx];
  assign dlvData     = stb.bypass ? rspData : dataBuf[headIdx];
endmodule

// File: rtl/lat_equalizer.sv
module lat_equalizer
  import lateq_pkg::*;
#(
  parameter int TAG_W     = 3,
  parameter int DATA_W    = 32,
  parameter int LAT_W     = 4,
  parameter int LAT_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latWrEn,
  input  logic [LAT_W-1:0]  latWrVal,
  input  logic              issueValid,
  output logic              issueReady,
  output logic [TAG_W-1:0]  issueTag,
  input  logic              rspValid,
  input  logic [TAG_W-1:0]  rspTag,
  input  logic [DATA_W-1:0] rspData,
  output logic              dlvValid,
  output logic [TAG_W-1:0]  dlvTag,
  output logic [DATA_W-1:0] dlvData,
  output logic              stall
);
  strobe_t          stb;
  logic             headArrived;
  logic [TAG_W-1:0] headIdx;

  lateq_ctrl #(.TAG_W(TAG_W), .LAT_W(LAT_W), .LAT_RESET(LAT_RESET)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .latWrEn     (latWrEn),
    .latWrVal    (latWrVal),
    .issueValid  (issueValid),
    .issueReady  (issueReady),
    .issueTag    (issueTag),
    .rspValid    (rspValid),
    .rspTag      (rspTag),
    .headArrived (headArrived),
    .stall       (stall),
    .dlvValid    (dlvValid),
    .headIdx     (headIdx),
    .stb         (stb)
  );

  lateq_dpath #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .headIdx     (headIdx),
    .rspTag      (rspTag),
    .rspData     (rspData),
    .headArrived (headArrived),
    .dlvData     (dlvData)
  );

  assign dlvTag = headIdx;
endmodule

// File: rtl/lateq_checker.sv
module lateq_checker #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issueValid,
  input logic             issueReady,
  input logic [TAG_W-1:0] issueTag,
  input logic             dlvValid,
  input logic [TAG_W-1:0] dlvTag,
  input logic             stall
);
  localparam logic [TAG_W:0] FULL_OCC = (TAG_W+1)'(1 << TAG_W);

  logic [TAG_W-1:0] nextIssueTag, nextDlvTag;
  logic [TAG_W:0]   inFlight;
  logic             fire;

  assign fire = issueValid && issueReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nextIssueTag <= '0;
      nextDlvTag   <= '0;
      inFlight     <= '0;
    end else begin
      if (fire)     nextIssueTag <= nextIssueTag + TAG_W'(1);
      if (dlvValid) nextDlvTag   <= nextDlvTag + TAG_W'(1);
      inFlight <= inFlight + (TAG_W+1)'(fire) - (TAG_W+1)'(dlvValid);
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (inFlight == '0) |-> (!dlvValid && !stall));

  a_r5_no_dlv_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !dlvValid);

  a_r7_stall_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !issueReady);

  a_r7_full_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (inFlight == FULL_OCC) |-> !issueReady);

  a_r7_tag_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (issueTag == nextIssueTag));

  a_r8_issue_order: assert property (@(posedge clk) disable iff (!rst_n)
    dlvValid |-> (dlvTag == nextDlvTag));
endmodule

bind lat_equalizer lateq_checker #(.TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issueValid (issueValid),
  .issueReady (issueReady),
  .issueTag   (issueTag),
  .dlvValid   (dlvValid),
  .dlvTag     (dlvTag),
  .stall      (stall)
);

// File: tb/tb_lat_equalizer.sv
module tb_lat_equalizer;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W  = 3;
  localparam int DATA_W = 32;
  localparam int LAT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              latWrEn = 1'b0;
  logic [LAT_W-1:0]  latWrVal = '0;
  logic              issueValid = 1'b0;
  logic              issueReady;
  logic [TAG_W-1:0]  issueTag;
  logic              rspValid = 1'b0;
  logic [TAG_W-1:0]  rspTag = '0;
  logic [DATA_W-1:0] rspData = '0;
  logic              dlvValid;
  logic [TAG_W-1:0]  dlvTag;
  logic [DATA_W-1:0] dlvData;
  logic              stall;

  int checks = 0;
  int failures = 0;
  int nextTag = 0;
  int loadNo = 0;
  bit done = 1'b0;

  lat_equalizer #(.TAG_W(TAG_W), .DATA_W(DATA_W), .LAT_W(LAT_W), .LAT_RESET(4)) dut (
    .clk(clk), .rst_n(rst_n), .latWrEn(latWrEn), .latWrVal(latWrVal),
    .issueValid(issueValid), .issueReady(issueReady), .issueTag(issueTag),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData),
    .dlvValid(dlvValid), .dlvTag(dlvTag), .dlvData(dlvData), .stall(stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int id);
    return 32'hC0DE0000 + id;
  endfunction

  task automatic quiet();
    issueValid = 1'b0; rspValid = 1'b0; latWrEn = 1'b0;
  endtask

  task automatic latWrite(input int v);
    @(negedge clk);
    quiet(); latWrEn = 1'b1; latWrVal = LAT_W'(v);
    @(negedge clk);
    latWrEn = 1'b0;
  endtask

  // One load, response driven d cycles after issue; optional latency write at wrT
  task automatic runSingle(input int n, input int d, input int wrT, input int wrVal, input string req);
    logic [TAG_W-1:0] tag = '0;
    logic [DATA_W-1:0] p;
    int e;
    e = (n > d) ? n : d;
    p = pat(loadNo); loadNo++;
    for (int t = 0; t <= e + 2; t++) begin
      @(negedge clk);
      issueValid = (t == 0);
      rspValid = (t == d); rspTag = tag; rspData = p;
      latWrEn = (t == wrT); latWrVal = LAT_W'(wrVal);
      #1;
      if (t == 0) begin
        chk(issueReady == 1'b1, "R7", "issueReady idle", issueReady, 1);
        chk(issueTag == TAG_W'(nextTag), "R7", "issueTag", issueTag, nextTag);
        tag = issueTag; nextTag = (nextTag + 1) % 8;
      end else begin
        chk(dlvValid == (t == e), req, $sformatf("dlvValid n=%0d d=%0d t=%0d", n, d, t), dlvValid, (t == e));
        chk(stall == (t >= n && t < d), "R5", $sformatf("stall n=%0d d=%0d t=%0d", n, d, t), stall, (t >= n && t < d));
        if (t == e) begin
          chk(dlvData == p, req, "dlvData", dlvData, p);
          chk(dlvTag == tag, "R2", "dlvTag", dlvTag, tag);
        end
      end
    end
    quiet();
  endtask

  // R6: load A late by s cycles, load B issued k cycles later
  task automatic runPair(input int n, input int k, input int s);
    logic [TAG_W-1:0] tA = '0, tB = '0;
    logic [DATA_W-1:0] pA, pB;
    int dA, dB;
    pA = pat(loadNo); pB = pat(loadNo + 1); loadNo += 2;
    dA = n + s; dB = k + n + s;
    for (int t = 0; t <= dB + 2; t++) begin
      @(negedge clk);
      issueValid = (t == 0 || t == k);
      rspValid = (t == n + s || t == n + s + 1);
      rspTag = (t == n + s) ? tA : tB;
      rspData = (t == n + s) ? pA : pB;
      #1;
      if (t == 0 || t == k) begin
        chk(issueReady == 1'b1, "R7", "issueReady pair", issueReady, 1);
        if (t == 0) tA = issueTag; else tB = issueTag;
        nextTag = (nextTag + 1) % 8;
      end
      if (t >= 1) begin
        chk(dlvValid == (t == dA || t == dB), "R6", $sformatf("dlvValid n=%0d k=%0d s=%0d t=%0d", n, k, s, t),
            dlvValid, (t == dA || t == dB));
        chk(stall == (t >= n && t < n + s), "R5", $sformatf("stall pair t=%0d", t), stall, (t >= n && t < n + s));
        if (t == dB) chk(dlvData == pB && dlvTag == tB, "R6", "second load data", dlvData, pB);
        if (t == dA) chk(dlvData == pA && dlvTag == tA, "R6", "first load data", dlvData, pA);
      end
    end
    quiet();
  endtask

  // R7/R8: eight loads back to back at latency 10, answered in swapped pairs
  task automatic runBurst();
    logic [TAG_W-1:0] tags [8];
    logic [DATA_W-1:0] pb [8];
    int ord [8] = '{1, 0, 3, 2, 5, 4, 7, 6};
    for (int i = 0; i < 8; i++) begin tags[i] = '0; pb[i] = pat(loadNo + i); end
    loadNo += 8;
    for (int t = 0; t <= 19; t++) begin
      @(negedge clk);
      issueValid = (t <= 8);
      rspValid = (t >= 2 && t <= 9);
      if (t >= 2 && t <= 9) begin
        rspTag = tags[ord[t-2]]; rspData = pb[ord[t-2]];
      end
      #1;
      if (t < 8) begin
        chk(issueReady == 1'b1, "R7", "issueReady burst", issueReady, 1);
        chk(issueTag == TAG_W'(nextTag), "R7", "burst tag", issueTag, nextTag);
        tags[t] = issueTag; nextTag = (nextTag + 1) % 8;
      end else if (t == 8) begin
        chk(issueReady == 1'b0, "R7", "issueReady with 8 outstanding", issueReady, 0);
        issueValid = 1'b0;
      end
      if (t >= 1) begin
        chk(dlvValid == (t >= 10 && t <= 17), "R8", $sformatf("burst dlvValid t=%0d", t), dlvValid, (t >= 10 && t <= 17));
        chk(stall == 1'b0, "R3", "burst stall", stall, 0);
        if (t >= 10 && t <= 17) begin
          chk(dlvTag == tags[t-10], "R8", "burst order tag", dlvTag, tags[t-10]);
          chk(dlvData == pb[t-10], "R8", "burst data", dlvData, pb[t-10]);
        end
      end
    end
    quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog run not finished actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lats [5] = '{1, 2, 3, 4, 6};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dlvValid == 1'b0, "R1", "dlvValid after reset", dlvValid, 0);
    chk(stall == 1'b0, "R1", "stall after reset", stall, 0);
    chk(issueReady == 1'b1, "R1", "issueReady after reset", issueReady, 1);
    // default latency 4, data early
    runSingle(4, 1, -1, 0, "R1");

    // R2/R3/R4/R5 sweep over latency and response offset
    foreach (lats[i]) begin
      latWrite(lats[i]);
      for (int d = 1; d <= lats[i] + 3; d++)
        runSingle(lats[i], d, -1, 0, (d < lats[i]) ? "R3" : (d == lats[i]) ? "R4" : "R2");
    end

    // R6 frozen countdowns
    for (int n = 2; n <= 5; n++) begin
      latWrite(n);
      for (int k = 1; k < n; k++)
        for (int s = 0; s <= 3; s++) runPair(n, k, s);
    end

    // R7 / R8
    latWrite(10);
    runBurst();

    // R9 latency write rules
    latWrite(2);
    runSingle(2, 1, -1, 0, "R9");
    runSingle(2, 1, 1, 5, "R9");     // write while a load is outstanding
    runSingle(2, 2, -1, 0, "R9");
    latWrite(0);                     // zero value
    runSingle(2, 1, -1, 0, "R9");
    runSingle(2, 1, 0, 7, "R9");     // write in the cycle a load is accepted
    runSingle(2, 3, -1, 0, "R9");

    // R10 stray response for the tag the next load will receive
    @(negedge clk);
    quiet(); rspValid = 1'b1; rspTag = TAG_W'(nextTag); rspData = 32'hBADBAD00;
    #1;
    chk(dlvValid == 1'b0, "R10", "stray response delivery", dlvValid, 0);
    @(negedge clk);
    quiet();
    #1;
    chk(dlvValid == 1'b0 && stall == 1'b0, "R10", "idle after stray", dlvValid, 0);
    runSingle(2, 4, -1, 0, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule